// File: doc/BRIEF.md
# Integer Execute Unit with Immediates

This block is the integer execute stage of a 32-bit, three-operand load/store processor. Each cycle it can accept one instruction word and the values of its two source registers, which the register file has already read. It decodes the instruction, selects the second operand, computes the result and returns it one clock later. The second operand is either the second register value or an immediate that has been widened according to the kind of operation. The result comes back with the index of the register to write and a write enable, so the writeback stage can use them directly.

Two encodings are handled. In the register form, the opcode is zero and a 6-bit function code in bits [5:0] selects the operation. The destination is in bits [15:11], and bits [10:6] are ignored. In the immediate form, the opcode in bits [31:26] selects the operation, the destination is in bits [20:16], and the constant is in bits [15:0]. The supported operations are add, subtract, AND, OR and signed set-less-than, each in register and immediate form, plus a load of a constant into the upper half of the register. Add and subtract wrap modulo 2^32 and never trap. An encoding the block does not know raises an illegal flag, and no write is issued for it.

Top module: `exu_core`

## Requirements
- R1: While `rstN` is low and on the first cycle after it is released, `outValid`, `writeEn` and `illegal` are all 0.
- R2: The outputs for an instruction presented with `inValid` high appear on the clock edge that samples it. `outValid` is high in the cycle after `inValid` is high, and low in the cycle after `inValid` is low.
- R3: With opcode 0x00, function code 0x20 gives `opA + opB` and function code 0x22 gives `opA - opB`. Both wrap modulo 2^32.
- R4: With opcode 0x00, function code 0x24 gives the bitwise AND of `opA` and `opB`, and function code 0x25 gives the bitwise OR.
- R5: With opcode 0x00 and function code 0x2A, the result is 1 when `opA` is less than `opB` as signed two's-complement numbers, and 0 otherwise.
- R6: Opcode 0x08 (add constant) and opcode 0x0A (signed less-than constant) sign-extend bits [15:0] to 32 bits and use that value as the second operand.
- R7: Opcode 0x0C (AND constant) and opcode 0x0D (OR constant) zero-extend bits [15:0] to 32 bits and use that value as the second operand.
- R8: Opcode 0x0F gives bits [15:0] times 65536, with the lower 16 bits zero. `opA` has no effect on this result.
- R9: `destIdx` is bits [15:11] for the register form and bits [20:16] for the immediate form.
- R10: When the destination index is 0, `writeEn` stays low, even if the operation is valid.
- R11: A register-form function code outside {0x20, 0x22, 0x24, 0x25, 0x2A}, or an opcode outside {0x00, 0x08, 0x0A, 0x0C, 0x0D, 0x0F}, sets `illegal` and keeps `writeEn` low.
- R12: A cycle with `inValid` low leads to `writeEn` and `illegal` both low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| opA | input | 32 | Value of the first source register |
| opB | input | 32 | Value of the second source register |
| outValid | output | 1 | Result registers hold a processed instruction |
| result | output | 32 | Computed result |
| destIdx | output | 5 | Index of the register to write |
| writeEn | output | 1 | Write the result to `destIdx` |
| illegal | output | 1 | The instruction was not recognised |

## Verification
The bench concentrates on how each kind of immediate is widened, using constants with bit 15 set. With such a constant, a design that sign-extends for the logical forms corrupts the upper half of the result, and one that zero-extends for add or compare gets `opA - 1` and the less-than outcome wrong. Set-less-than is tested with operands of opposite sign, where an unsigned comparison returns the inverted answer. A wrapping add and a subtract that goes negative expose a result that is truncated or saturated. The bench also covers writes aimed at register 0, unknown opcodes and function codes, and idle cycles. A design with the destination fields swapped, or one that lets a suppressed instruction write, fails the `destIdx` or `writeEn` checks.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int INSTR_W   = 32;
  localparam int OPC_W     = 6;
  localparam int FUNC_W    = 6;
  localparam int REG_IDX_W = 5;
  localparam int IMM_W     = 16;

  // instruction field positions (decoded by neighbours too)
  localparam int OPC_LSB = 26;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;

  // opcode values
  localparam logic [OPC_W-1:0] OPC_REGFORM = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDK    = 6'h08;
  localparam logic [OPC_W-1:0] OPC_LTK     = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDK    = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORK     = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_HIK     = 6'h0F;

  // function codes of the register form
  localparam logic [FUNC_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNC_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNC_W-1:0] FN_LT  = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT,
    ALU_PASSB
  } aluOp_e;

  typedef enum logic [1:0] {
    IMM_NONE,
    IMM_SIGN,
    IMM_ZERO,
    IMM_UPPER
  } immKind_e;

  typedef struct packed {
    aluOp_e   aluOp;
    immKind_e immKind;
    logic     destFromRd;
    logic     writeReq;
    logic     illegal;
  } exuCtrl_t;

endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FUNC_W-1:0] funct,
  output exuCtrl_t          ctrl
);

  exuCtrl_t regForm;
  exuCtrl_t immForm;

  // register-register operations: selected by function code
  always_comb begin
    regForm            = '0;
    regForm.aluOp      = ALU_ADD;
    regForm.immKind    = IMM_NONE;
    regForm.destFromRd = 1'b1;
    regForm.writeReq   = 1'b1;
    regForm.illegal    = 1'b0;
    unique case (funct)
      FN_ADD:  regForm.aluOp = ALU_ADD;
      FN_SUB:  regForm.aluOp = ALU_SUB;
      FN_AND:  regForm.aluOp = ALU_AND;
      FN_OR:   regForm.aluOp = ALU_OR;
      FN_LT:   regForm.aluOp = ALU_SLT;
      default: begin
        regForm.writeReq = 1'b0;
        regForm.illegal  = 1'b1;
      end
    endcase
  end

  // register-immediate operations: opcode picks both the op and the
  // way the constant is widened
  always_comb begin
    immForm            = '0;
    immForm.aluOp      = ALU_ADD;
    immForm.immKind    = IMM_SIGN;
    immForm.destFromRd = 1'b0;
    immForm.writeReq   = 1'b1;
    immForm.illegal    = 1'b0;
    unique case (opcode)
      OPC_ADDK: begin
        immForm.aluOp   = ALU_ADD;
        immForm.immKind = IMM_SIGN;
      end
      OPC_LTK: begin
        immForm.aluOp   = ALU_SLT;
        immForm.immKind = IMM_SIGN;
      end
      OPC_ANDK: begin
        immForm.aluOp   = ALU_AND;
        immForm.immKind = IMM_ZERO;
      end
      OPC_ORK: begin
        immForm.aluOp   = ALU_OR;
        immForm.immKind = IMM_ZERO;
      end
      OPC_HIK: begin
        immForm.aluOp   = ALU_PASSB;
        immForm.immKind = IMM_UPPER;
      end
      default: begin
        immForm.writeReq = 1'b0;
        immForm.illegal  = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (opcode == OPC_REGFORM) ctrl = regForm;
    else                       ctrl = immForm;
  end

endmodule

// File: rtl/exu_dpath.sv
module exu_dpath
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  exuCtrl_t             ctrl,
  input  logic [IMM_W-1:0]     imm,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  output logic                 outValid,
  output logic [DATA_W-1:0]    result,
  output logic [REG_IDX_W-1:0] destIdx,
  output logic                 writeEn,
  output logic                 illegal
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0]    immSext;
  logic [DATA_W-1:0]    immZext;
  logic [DATA_W-1:0]    immUpper;
  logic [DATA_W-1:0]    operandB;
  logic [DATA_W-1:0]    aluOut;
  logic                 signedLess;
  logic [REG_IDX_W-1:0] destNext;
  logic                 writeNext;

  // constant widening, one variant per operation class
  assign immSext  = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign immZext  = {{EXT_W{1'b0}}, imm};
  assign immUpper = immZext << IMM_W;

  always_comb begin
    unique case (ctrl.immKind)
      IMM_SIGN:  operandB = immSext;
      IMM_ZERO:  operandB = immZext;
      IMM_UPPER: operandB = immUpper;
      default:   operandB = opB;
    endcase
  end

  assign signedLess = $signed(opA) < $signed(operandB);

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD:   aluOut = opA + operandB;
      ALU_SUB:   aluOut = opA - operandB;
      ALU_AND:   aluOut = opA & operandB;
      ALU_OR:    aluOut = opA | operandB;
      ALU_SLT:   aluOut = {{(DATA_W-1){1'b0}}, signedLess};
      default:   aluOut = operandB;
    endcase
  end

  assign destNext  = ctrl.destFromRd ? rdIdx : rtIdx;
  assign writeNext = inValid && ctrl.writeReq && (destNext != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      destIdx  <= '0;
      writeEn  <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      writeEn  <= writeNext;
      illegal  <= inValid && ctrl.illegal;
      if (inValid) begin
        result  <= aluOut;
        destIdx <= destNext;
      end
    end
  end

  // R2: result registers follow the input strobe by one edge
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8: upper-half constant leaves the low half clear
  a_r8_upper_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrl.immKind == IMM_UPPER) |=> (result[IMM_W-1:0] == '0));

  // R5: compare result is a single bit
  a_r5_slt_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrl.aluOp == ALU_SLT) |=> (result[DATA_W-1:1] == '0));

  // R7: zero-extended logical AND cannot set upper bits
  a_r7_andk_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrl.aluOp == ALU_AND && ctrl.immKind == IMM_ZERO)
      |=> (result[DATA_W-1:IMM_W] == '0));

endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  output logic                 outValid,
  output logic [DATA_W-1:0]    result,
  output logic [REG_IDX_W-1:0] destIdx,
  output logic                 writeEn,
  output logic                 illegal
);

  exuCtrl_t ctrl;
  logic     unusedFields;

  // source index and shift amount are not consumed here
  assign unusedFields = ^{instr[25:21], instr[10:6]};

  exu_ctrl u_ctrl (
    .opcode (instr[OPC_LSB +: OPC_W]),
    .funct  (instr[FUNC_W-1:0]),
    .ctrl   (ctrl)
  );

  exu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .imm      (instr[IMM_W-1:0]),
    .rtIdx    (instr[RT_LSB +: REG_IDX_W]),
    .rdIdx    (instr[RD_LSB +: REG_IDX_W]),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .result   (result),
    .destIdx  (destIdx),
    .writeEn  (writeEn),
    .illegal  (illegal)
  );

  // R11: an unrecognised instruction never writes
  a_r11_illegal_no_write: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !writeEn);

  // R10: register 0 is never a write target
  a_r10_no_zero_write: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> (destIdx != '0));

  // R12: idle output carries no write and no fault
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!writeEn && !illegal));

endmodule

// File: tb/sim_exu_core.sv
`timescale 1ns/1ps
module sim_exu_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] result;
  logic [4:0]  destIdx;
  logic        writeEn;
  logic        illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exu_core u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .destIdx(destIdx), .writeEn(writeEn), .illegal(illegal)
  );

  function automatic logic [31:0] rWord(input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, 5'd1, 5'd2, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] iWord(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [15:0] k);
    return {op, 5'd1, rt, k};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one instruction, sample one edge later
  task automatic runOp(input string tag, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expRes, input logic [4:0] expDest,
                       input logic expWe, input logic expIll);
    @(negedge clk);
    inValid = 1'b1; instr = w; opA = a; opB = b;
    @(posedge clk); #1;
    check(tag, "outValid", {31'b0, outValid}, 32'd1);
    check(tag, "writeEn", {31'b0, writeEn}, {31'b0, expWe});
    check(tag, "illegal", {31'b0, illegal}, {31'b0, expIll});
    if (!expIll) begin
      check(tag, "result", result, expRes);
      check(tag, "destIdx", {27'b0, destIdx}, {27'b0, expDest});
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check("R1", "outValid", {31'b0, outValid}, 32'd0);
    check("R1", "writeEn", {31'b0, writeEn}, 32'd0);
    check("R1", "illegal", {31'b0, illegal}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", "outValid after release", {31'b0, outValid}, 32'd0);
  endtask

  task automatic testRegArith();
    runOp("R3", rWord(5'd3, 6'h20), 32'd7, 32'd5, 32'd12, 5'd3, 1'b1, 1'b0);
    runOp("R3", rWord(5'd4, 6'h20), 32'hFFFF_FFFF, 32'd2, 32'd1, 5'd4, 1'b1, 1'b0);
    runOp("R3", rWord(5'd5, 6'h22), 32'd5, 32'd7, 32'hFFFF_FFFE, 5'd5, 1'b1, 1'b0);
  endtask

  task automatic testRegLogic();
    logic [31:0] x = 32'hDF5A_48F5;
    logic [31:0] y = 32'hF0F0_F0F0;
    runOp("R4", rWord(5'd6, 6'h24), x, y, x & y, 5'd6, 1'b1, 1'b0);
    runOp("R4", rWord(5'd7, 6'h25), x, y, x | y, 5'd7, 1'b1, 1'b0);
  endtask

  task automatic testCompare();
    runOp("R5", rWord(5'd8, 6'h2A), 32'hFFFF_FFFF, 32'd1, 32'd1, 5'd8, 1'b1, 1'b0);
    runOp("R5", rWord(5'd8, 6'h2A), 32'd5, 32'hFFFF_FFFD, 32'd0, 5'd8, 1'b1, 1'b0);
    runOp("R5", rWord(5'd8, 6'h2A), 32'd9, 32'd9, 32'd0, 5'd8, 1'b1, 1'b0);
  endtask

  task automatic testSignedImm();
    // R6 and R9: destination comes from bits [20:16]
    runOp("R6", iWord(6'h08, 5'd9, 16'hFFFF), 32'd100, 32'hDEAD_BEEF, 32'd99, 5'd9, 1'b1, 1'b0);
    runOp("R6", iWord(6'h0A, 5'd10, 16'hFFFF), 32'hFFFF_FFFE, 32'd0, 32'd1, 5'd10, 1'b1, 1'b0);
    runOp("R6", iWord(6'h0A, 5'd10, 16'h8000), 32'd0, 32'd0, 32'd0, 5'd10, 1'b1, 1'b0);
  endtask

  task automatic testZeroImm();
    runOp("R7", iWord(6'h0C, 5'd11, 16'h8001), 32'hFFFF_FFFF, 32'd0, 32'h0000_8001, 5'd11, 1'b1, 1'b0);
    runOp("R7", iWord(6'h0D, 5'd12, 16'hF000), 32'h0001_0000, 32'hFFFF_FFFF, 32'h0001_F000, 5'd12, 1'b1, 1'b0);
  endtask

  task automatic testUpper();
    runOp("R8", iWord(6'h0F, 5'd13, 16'h1234), 32'hFFFF_FFFF, 32'h5555_5555, 32'h1234_0000, 5'd13, 1'b1, 1'b0);
    runOp("R8", iWord(6'h0F, 5'd13, 16'hFFFF), 32'd0, 32'd0, 32'hFFFF_0000, 5'd13, 1'b1, 1'b0);
  endtask

  task automatic testDestSelect();
    // R9: register form with distinct rt (2) and rd (17)
    runOp("R9", rWord(5'd17, 6'h20), 32'd1, 32'd1, 32'd2, 5'd17, 1'b1, 1'b0);
  endtask

  task automatic testZeroDest();
    runOp("R10", rWord(5'd0, 6'h20), 32'd3, 32'd4, 32'd7, 5'd0, 1'b0, 1'b0);
    runOp("R10", iWord(6'h0D, 5'd0, 16'h00FF), 32'd0, 32'd0, 32'h0000_00FF, 5'd0, 1'b0, 1'b0);
  endtask

  task automatic testIllegal();
    runOp("R11", rWord(5'd3, 6'h3F), 32'd1, 32'd2, 32'd0, 5'd0, 1'b0, 1'b1);
    runOp("R11", iWord(6'h3F, 5'd3, 16'h0001), 32'd1, 32'd2, 32'd0, 5'd0, 1'b0, 1'b1);
    runOp("R11", iWord(6'h02, 5'd3, 16'h0001), 32'd1, 32'd2, 32'd0, 5'd0, 1'b0, 1'b1);
  endtask

  task automatic testIdle();
    @(negedge clk);
    inValid = 1'b0; instr = rWord(5'd3, 6'h20); opA = 32'd1; opB = 32'd1;
    @(posedge clk); #1;
    check("R12", "writeEn", {31'b0, writeEn}, 32'd0);
    check("R12", "illegal", {31'b0, illegal}, 32'd0);
    check("R2", "outValid idle", {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    testReset();
    testRegArith();
    testRegLogic();
    testCompare();
    testSignedImm();
    testZeroImm();
    testUpper();
    testDestSelect();
    testZeroDest();
    testIllegal();
    testIdle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule